// File: doc/BRIEF.md
# Attribute-Steered Direct-Mapped Data Cache Controller

This block sits between a load/store unit and external memory and holds a small direct-mapped data cache. Every request carries three attribute bits, X, C and B, that pick at run time whether the access may be cached. They also pick whether a store miss allocates a line, whether stores write through to memory or stay in the line as dirty data, and whether an external word write may be buffered and merged. A global `mmu_en` input set low overrides the attributes, so every access goes to memory uncached and unbuffered.

The core raises `req_valid` and holds all request fields until `req_done` pulses for one cycle. Load data appears on `req_rdata` during that cycle. Line fills and dirty-line write-backs move eight 32-bit words over the line port, one word per `line_ack`, in ascending address order. Uncached loads and all stores that go straight to memory use the single-word port. A separate clean request, held until `clean_done`, writes back a dirty line at a chosen index and leaves that line valid.

Address fields: bits [1:0] are the byte offset, bits [4:2] the word in the line, the next log2(LINES) bits the index, and the remaining upper bits the tag. Cacheable means `mmu_en`=1 and C=1.

Top module: `attr_dcache`

## Requirements
- R1: With `mmu_en` low, every request is handled as uncached and unbuffered, whatever X, C and B say: no line fill, no cache update, `word_buf`=0 and `word_merge`=0 on its word write, and `attr_err`=0.
- R2: With `mmu_en` high and C=0, a store never fills, evicts or updates a line and goes out as one word write.
- R3: Read-allocate encodings {X,C,B} = 010, 011 and 110: a load miss fetches the whole line (8 words) and returns the requested word. A store miss issues a single word write and allocates nothing.
- R4: Encoding 111 allocates on any miss. A store miss fills the line, merges the store bytes into it, marks it dirty and issues no word write.
- R5: Encoding 010 is write-through. A store hit updates the line and also issues one word write carrying the same byte enables, and the line stays clean.
- R6: Encodings 011, 110 and 111 are write-back. A store hit only updates the line and marks it dirty. A dirty line is written back (8 words) before its slot is refilled with another tag.
- R7: An uncached load performs exactly one word read, returns that word and leaves cache contents unchanged.
- R8: On a word write, `word_buf` equals B and `word_merge` equals B, except that encoding 101 gives `word_merge`=0. Encodings 010 and 000 give `word_buf`=0.
- R9: Encoding 100 with `mmu_en` high raises `attr_err` together with `req_done` and is served uncached and unbuffered.
- R10: A clean request on a dirty line writes its 8 words back and clears the dirty bit, and a later load of that line is a hit. On a clean or invalid line it completes with no transfer.
- R11: Line transfers start at the line base address and step by 4 bytes per acknowledged beat, so the word field (bits [4:2]) goes 0 to 7.
- R12: A cacheable load hit returns the line's current contents, including stores not yet written to memory.
- R13: After reset all lines are invalid, and no done, error or transfer request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mmu_en | input | 1 | Global enable for attribute handling; low forces uncached, unbuffered access |
| req_valid | input | 1 | Request present; held until req_done |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| req_be | input | DATA_W/8 | Store byte enables |
| req_x | input | 1 | Attribute X |
| req_c | input | 1 | Attribute C (cacheable) |
| req_b | input | 1 | Attribute B (bufferable) |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | DATA_W | Load data, valid with req_done |
| attr_err | output | 1 | Invalid attribute encoding, valid with req_done |
| clean_valid | input | 1 | Clean request; held until clean_done |
| clean_index | input | log2(LINES) | Line to clean |
| clean_done | output | 1 | One-cycle clean completion pulse |
| line_req | output | 1 | Line transfer beat requested |
| line_we | output | 1 | 1 = write-back beat, 0 = fill beat |
| line_addr | output | ADDR_W | Word address of the current beat |
| line_wdata | output | DATA_W | Write-back data of the current beat |
| line_rdata | input | DATA_W | Fill data of the current beat |
| line_ack | input | 1 | Memory accepts or returns the current beat |
| word_req | output | 1 | Single-word access requested |
| word_we | output | 1 | 1 = word write, 0 = word read |
| word_addr | output | ADDR_W | Request address |
| word_wdata | output | DATA_W | Word write data |
| word_be | output | DATA_W/8 | Word write byte enables |
| word_buf | output | 1 | Word write may be buffered |
| word_merge | output | 1 | Buffered word write may merge with earlier ones |
| word_rdata | input | DATA_W | Word read data |
| word_ack | input | 1 | Memory completes the word access |

## Verification
The bench builds the block with LINES=4 and keeps the 32-bit word and 32-byte line. Four tags over four indices then cover a 512-byte space. A few hundred requests force frequent conflicts, dirty evictions, hits after fills, and stale-line cases. The sweep steps through every X/C/B encoding, with and without `mmu_en`, for loads and stores. A reference model of tags, dirty bits, line contents and external memory, derived from the requirements, predicts each load value, the beat and word counts, and the buffer flags. Closing cleans of every line then compare all of memory against the model.

// File: rtl/dc_pkg.sv
package dc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_FILL,
    ST_WORD,
    ST_RESP
  } dc_state_e;

  typedef struct packed {
    logic cacheable;
    logic write_back;
    logic wr_alloc;
    logic bufferable;
    logic merge_ok;
    logic bad_enc;
  } dc_policy_t;

endpackage

// File: rtl/dc_attr_decode.sv
module dc_attr_decode
  import dc_pkg::*;
(
  input  logic       mmu_en,
  input  logic       attr_x,
  input  logic       attr_c,
  input  logic       attr_b,
  output dc_policy_t pol
);

  always_comb begin
    pol = '0;
    if (mmu_en) begin
      unique case ({attr_x, attr_c, attr_b})
        3'b001: begin
          pol.bufferable = 1'b1;
          pol.merge_ok   = 1'b1;
        end
        3'b010: begin
          pol.cacheable = 1'b1;
        end
        3'b011: begin
          pol.cacheable  = 1'b1;
          pol.write_back = 1'b1;
          pol.bufferable = 1'b1;
          pol.merge_ok   = 1'b1;
        end
        3'b100: begin
          pol.bad_enc = 1'b1;
        end
        3'b101: begin
          pol.bufferable = 1'b1;
        end
        3'b110: begin
          pol.cacheable  = 1'b1;
          pol.write_back = 1'b1;
        end
        3'b111: begin
          pol.cacheable  = 1'b1;
          pol.write_back = 1'b1;
          pol.wr_alloc   = 1'b1;
          pol.bufferable = 1'b1;
          pol.merge_ok   = 1'b1;
        end
        default: pol = '0;
      endcase
    end
  end

endmodule

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
  parameter int LINES = 8,
  parameter int TAG_W = 24,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic             wr_dirty,
  input  logic [TAG_W-1:0] wr_tag
);

  logic [LINES-1:0] valid_vec;
  logic [LINES-1:0] dirty_vec;
  logic [TAG_W-1:0] tag_arr [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic             sel;
    logic             v_q;
    logic             d_q;
    logic [TAG_W-1:0] t_q;

    assign sel = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= 1'b0;
      end else if (sel) begin
        v_q <= wr_valid;
        d_q <= wr_dirty;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        t_q <= wr_tag;
      end
    end

    assign valid_vec[i] = v_q;
    assign dirty_vec[i] = d_q;
    assign tag_arr[i]   = t_q;
  end

  assign rd_valid = valid_vec[rd_idx];
  assign rd_dirty = dirty_vec[rd_idx];
  assign rd_tag   = tag_arr[rd_idx];

endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
  parameter int LINES  = 8,
  parameter int WPL    = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W   = $clog2(LINES),
  localparam int WOFF_W  = $clog2(WPL),
  localparam int BE_W    = DATA_W / 8,
  localparam int ENTRIES = LINES * WPL
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WOFF_W-1:0] rd_word,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WOFF_W-1:0] wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BE_W-1:0]   wr_be
);

  logic [DATA_W-1:0] mem [ENTRIES];

  assign rd_data = mem[{rd_idx, rd_word}];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < BE_W; l++) begin
        if (wr_be[l]) begin
          mem[{wr_idx, wr_word}][l*8 +: 8] <= wr_data[l*8 +: 8];
        end
      end
    end
  end

endmodule

// File: rtl/attr_dcache.sv
module attr_dcache
  import dc_pkg::*;
#(
  parameter int LINES      = 8,
  parameter int LINE_BYTES = 32,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  localparam int BE_W   = DATA_W / 8,
  localparam int WPL    = LINE_BYTES / BE_W,
  localparam int BOFF_W = $clog2(BE_W),
  localparam int WOFF_W = $clog2(WPL),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - WOFF_W - BOFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mmu_en,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  input  logic              req_x,
  input  logic              req_c,
  input  logic              req_b,
  output logic              req_done,
  output logic [DATA_W-1:0] req_rdata,
  output logic              attr_err,
  input  logic              clean_valid,
  input  logic [IDX_W-1:0]  clean_index,
  output logic              clean_done,
  output logic              line_req,
  output logic              line_we,
  output logic [ADDR_W-1:0] line_addr,
  output logic [DATA_W-1:0] line_wdata,
  input  logic [DATA_W-1:0] line_rdata,
  input  logic              line_ack,
  output logic              word_req,
  output logic              word_we,
  output logic [ADDR_W-1:0] word_addr,
  output logic [DATA_W-1:0] word_wdata,
  output logic [BE_W-1:0]   word_be,
  output logic              word_buf,
  output logic              word_merge,
  input  logic [DATA_W-1:0] word_rdata,
  input  logic              word_ack
);

  localparam logic [WOFF_W-1:0] LAST_BEAT = WOFF_W'(WPL - 1);

  // Registered state
  dc_state_e         state_q, state_d;
  logic [WOFF_W-1:0] beat_q, beat_d;
  logic              clean_op_q, clean_op_d;
  logic              err_q, err_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  // Request fields
  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [WOFF_W-1:0] req_word;
  dc_policy_t        pol;

  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign req_idx  = req_addr[BOFF_W+WOFF_W +: IDX_W];
  assign req_word = req_addr[BOFF_W +: WOFF_W];

  dc_attr_decode u_decode (
    .mmu_en (mmu_en),
    .attr_x (req_x),
    .attr_c (req_c),
    .attr_b (req_b),
    .pol    (pol)
  );

  // Index currently worked on: a clean request wins in idle
  logic             use_clean;
  logic [IDX_W-1:0] cur_idx;

  assign use_clean = (state_q == ST_IDLE) ? clean_valid : clean_op_q;
  assign cur_idx   = use_clean ? clean_index : req_idx;

  // Tag store
  logic             t_valid, t_dirty;
  logic [TAG_W-1:0] t_tag;
  logic             tag_we;
  logic             tag_wvalid, tag_wdirty;
  logic [TAG_W-1:0] tag_wtag;

  dc_tag_store #(
    .LINES (LINES),
    .TAG_W (TAG_W)
  ) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (cur_idx),
    .rd_valid (t_valid),
    .rd_dirty (t_dirty),
    .rd_tag   (t_tag),
    .wr_en    (tag_we),
    .wr_idx   (cur_idx),
    .wr_valid (tag_wvalid),
    .wr_dirty (tag_wdirty),
    .wr_tag   (tag_wtag)
  );

  // Data store
  logic [WOFF_W-1:0] d_rword;
  logic [DATA_W-1:0] d_rdata;
  logic              dat_we;
  logic [WOFF_W-1:0] dat_wword;
  logic [DATA_W-1:0] dat_wdata;
  logic [BE_W-1:0]   dat_wbe;

  assign d_rword = (state_q == ST_EVICT) ? beat_q : req_word;

  dc_data_store #(
    .LINES  (LINES),
    .WPL    (WPL),
    .DATA_W (DATA_W)
  ) u_data (
    .clk     (clk),
    .rd_idx  (cur_idx),
    .rd_word (d_rword),
    .rd_data (d_rdata),
    .wr_en   (dat_we),
    .wr_idx  (cur_idx),
    .wr_word (dat_wword),
    .wr_data (dat_wdata),
    .wr_be   (dat_wbe)
  );

  // Lookup
  logic hit;
  logic victim_dirty;
  logic last_ack;

  assign hit          = pol.cacheable && t_valid && (t_tag == req_tag);
  assign victim_dirty = t_valid && t_dirty;
  assign last_ack     = line_ack && (beat_q == LAST_BEAT);

  // Next-state logic
  always_comb begin
    state_d    = state_q;
    beat_d     = beat_q;
    clean_op_d = clean_op_q;
    err_d      = err_q;
    rdata_d    = rdata_q;
    tag_we     = 1'b0;
    tag_wvalid = t_valid;
    tag_wdirty = t_dirty;
    tag_wtag   = t_tag;
    dat_we     = 1'b0;
    dat_wword  = req_word;
    dat_wdata  = req_wdata;
    dat_wbe    = req_be;

    unique case (state_q)
      ST_IDLE: begin
        beat_d = '0;
        if (clean_valid) begin
          clean_op_d = 1'b1;
          err_d      = 1'b0;
          state_d    = victim_dirty ? ST_EVICT : ST_RESP;
        end else if (req_valid) begin
          clean_op_d = 1'b0;
          err_d      = pol.bad_enc;
          if (!req_write) begin
            if (hit) begin
              rdata_d = d_rdata;
              state_d = ST_RESP;
            end else if (pol.cacheable) begin
              state_d = victim_dirty ? ST_EVICT : ST_FILL;
            end else begin
              state_d = ST_WORD;
            end
          end else begin
            if (hit) begin
              dat_we = 1'b1;
              if (pol.write_back) begin
                tag_we     = 1'b1;
                tag_wdirty = 1'b1;
                state_d    = ST_RESP;
              end else begin
                state_d = ST_WORD;
              end
            end else if (pol.cacheable && pol.wr_alloc) begin
              state_d = victim_dirty ? ST_EVICT : ST_FILL;
            end else begin
              state_d = ST_WORD;
            end
          end
        end
      end

      ST_EVICT: begin
        if (line_ack) begin
          beat_d = beat_q + 1'b1;
          if (last_ack) begin
            beat_d = '0;
            if (clean_op_q) begin
              tag_we     = 1'b1;
              tag_wdirty = 1'b0;
              state_d    = ST_RESP;
            end else begin
              state_d = ST_FILL;
            end
          end
        end
      end

      ST_FILL: begin
        dat_wword = beat_q;
        dat_wdata = line_rdata;
        dat_wbe   = '1;
        if (line_ack) begin
          dat_we = 1'b1;
          beat_d = beat_q + 1'b1;
          if (last_ack) begin
            beat_d     = '0;
            tag_we     = 1'b1;
            tag_wvalid = 1'b1;
            tag_wdirty = 1'b0;
            tag_wtag   = req_tag;
            state_d    = ST_IDLE;  // request is replayed and now hits
          end
        end
      end

      ST_WORD: begin
        if (word_ack) begin
          rdata_d = word_rdata;
          state_d = ST_RESP;
        end
      end

      ST_RESP: begin
        state_d = ST_IDLE;
      end

      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      beat_q     <= '0;
      clean_op_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      state_q    <= state_d;
      beat_q     <= beat_d;
      clean_op_q <= clean_op_d;
      err_q      <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    rdata_q <= rdata_d;
  end

  // Outputs
  logic [TAG_W-1:0] line_tag;

  assign line_tag   = (state_q == ST_EVICT) ? t_tag : req_tag;
  assign line_req   = (state_q == ST_EVICT) || (state_q == ST_FILL);
  assign line_we    = (state_q == ST_EVICT);
  assign line_addr  = {line_tag, cur_idx, beat_q, {BOFF_W{1'b0}}};
  assign line_wdata = d_rdata;

  assign word_req   = (state_q == ST_WORD);
  assign word_we    = req_write;
  assign word_addr  = req_addr;
  assign word_wdata = req_wdata;
  assign word_be    = req_be;
  assign word_buf   = word_req && req_write && pol.bufferable;
  assign word_merge = word_req && req_write && pol.merge_ok;

  assign req_done   = (state_q == ST_RESP) && !clean_op_q;
  assign clean_done = (state_q == ST_RESP) && clean_op_q;
  assign attr_err   = req_done && err_q;
  assign req_rdata  = rdata_q;

endmodule

// File: rtl/dc_checker.sv
module dc_checker #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 32,
  localparam int BE_W   = DATA_W / 8,
  localparam int WPL    = LINE_BYTES / BE_W,
  localparam int BOFF_W = $clog2(BE_W),
  localparam int WOFF_W = $clog2(WPL)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mmu_en,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_x,
  input logic              req_c,
  input logic              req_b,
  input logic              req_done,
  input logic              clean_done,
  input logic              attr_err,
  input logic              line_req,
  input logic              line_we,
  input logic              line_ack,
  input logic [ADDR_W-1:0] line_addr,
  input logic              word_req
);

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    attr_err |-> req_done);  // R9

  AST_ONE_PORT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_req && word_req));  // R7

  AST_DONE_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_done && clean_done));  // R10

  AST_FILL_NEEDS_CACHEABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_req && !line_we) |-> (req_valid && mmu_en && req_c));  // R1

  AST_STORE_FILL_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (line_req && !line_we && req_write) |-> (req_x && req_c && req_b));  // R3

  AST_BEAT_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (line_req && line_ack && (line_addr[BOFF_W +: WOFF_W] != {WOFF_W{1'b1}}))
      |=> (line_req && (line_addr == $past(line_addr) + ADDR_W'(BE_W))));  // R11

endmodule

bind attr_dcache dc_checker #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .LINE_BYTES (LINE_BYTES)
) u_dc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .mmu_en     (mmu_en),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_x      (req_x),
  .req_c      (req_c),
  .req_b      (req_b),
  .req_done   (req_done),
  .clean_done (clean_done),
  .attr_err   (attr_err),
  .line_req   (line_req),
  .line_we    (line_we),
  .line_ack   (line_ack),
  .line_addr  (line_addr),
  .word_req   (word_req)
);

// File: tb/test_attr_dcache.sv
module test_attr_dcache;

  localparam int LINES = 4;
  localparam int NW    = 128;  // words in the modelled 512-byte space

  logic        clk;
  logic        rst_n;
  logic        mmu_en;
  logic        req_valid, req_write;
  logic [31:0] req_addr, req_wdata;
  logic [3:0]  req_be;
  logic        req_x, req_c, req_b;
  logic        req_done, attr_err;
  logic [31:0] req_rdata;
  logic        clean_valid;
  logic [1:0]  clean_index;
  logic        clean_done;
  logic        line_req, line_we, line_ack;
  logic [31:0] line_addr, line_wdata, line_rdata;
  logic        word_req, word_we, word_buf, word_merge, word_ack;
  logic [31:0] word_addr, word_wdata, word_rdata;
  logic [3:0]  word_be;

  attr_dcache #(.LINES(LINES)) i_attr_dcache (
    .clk(clk), .rst_n(rst_n), .mmu_en(mmu_en),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .req_x(req_x), .req_c(req_c), .req_b(req_b),
    .req_done(req_done), .req_rdata(req_rdata), .attr_err(attr_err),
    .clean_valid(clean_valid), .clean_index(clean_index), .clean_done(clean_done),
    .line_req(line_req), .line_we(line_we), .line_addr(line_addr), .line_wdata(line_wdata),
    .line_rdata(line_rdata), .line_ack(line_ack),
    .word_req(word_req), .word_we(word_we), .word_addr(word_addr), .word_wdata(word_wdata),
    .word_be(word_be), .word_buf(word_buf), .word_merge(word_merge),
    .word_rdata(word_rdata), .word_ack(word_ack)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // Memory model: zero-wait acknowledge
  logic [31:0] mem [NW];
  assign line_ack   = line_req;
  assign word_ack   = word_req;
  assign line_rdata = mem[line_addr[8:2]];
  assign word_rdata = mem[word_addr[8:2]];

  int fill_beats, ev_beats, wrd_cnt, wwr_cnt, beat_cnt;
  bit seen_buf, seen_merge;

  always @(posedge clk) begin
    if (rst_n && line_req) begin
      chk(line_addr[4:2] == 3'(beat_cnt), "R11", "beat word", line_addr[4:2], beat_cnt % 8);
      beat_cnt = (beat_cnt + 1) % 8;
      if (line_we) begin
        mem[line_addr[8:2]] <= line_wdata;
        ev_beats++;
      end else begin
        fill_beats++;
      end
    end
    if (rst_n && word_req) begin
      if (word_we) begin
        for (int l = 0; l < 4; l++)
          if (word_be[l]) mem[word_addr[8:2]][l*8 +: 8] <= word_wdata[l*8 +: 8];
        wwr_cnt++;
        seen_buf   = word_buf;
        seen_merge = word_merge;
      end else begin
        wrd_cnt++;
      end
    end
  end

  // Reference model
  bit          mv [LINES];
  bit          md [LINES];
  int          mt [LINES];
  logic [31:0] cdat [LINES][8];
  logic [31:0] ext [NW];

  function automatic logic [31:0] merge_be(input logic [31:0] old, input logic [31:0] nw,
                                           input logic [3:0] be);
    logic [31:0] r = old;
    for (int l = 0; l < 4; l++) if (be[l]) r[l*8 +: 8] = nw[l*8 +: 8];
    return r;
  endfunction

  task automatic model_evict(input int idx);
    for (int w = 0; w < 8; w++) ext[mt[idx]*32 + idx*8 + w] = cdat[idx][w];
    md[idx] = 0;
  endtask

  task automatic model_fill(input int idx, input int tag);
    for (int w = 0; w < 8; w++) cdat[idx][w] = ext[tag*32 + idx*8 + w];
    mv[idx] = 1; md[idx] = 0; mt[idx] = tag;
  endtask

  task automatic reset_counters();
    fill_beats = 0; ev_beats = 0; wrd_cnt = 0; wwr_cnt = 0; beat_cnt = 0;
    seen_buf = 0; seen_merge = 0;
  endtask

  task automatic do_req(input bit mmu, input logic [2:0] xcb, input bit we,
                        input logic [31:0] addr, input logic [31:0] wd, input logic [3:0] be);
    bit x = xcb[2], c = xcb[1], b = xcb[0];
    bit cach = mmu & c, wb = mmu & c & (b | x), walloc = mmu & x & c & b;
    bit err = mmu & x & !c & !b, e_buf = mmu & b, e_mrg = mmu & b & !(x & !c);
    int idx = int'(addr[6:5]), tag = int'(addr[8:7]), w = int'(addr[4:2]);
    int wi = int'(addr[8:2]);
    bit hit = cach && mv[idx] && (mt[idx] == tag);
    int e_fill = 0, e_ev = 0, e_wr = 0, e_ww = 0;
    logic [31:0] e_rd = '0;
    string rq;
    int cyc = 0;

    if (!mmu) rq = "R1";
    else if (err) rq = "R9";
    else if (!c) rq = we ? "R2" : "R7";
    else if (!we) rq = "R3";
    else if (walloc) rq = "R4";
    else if (wb) rq = hit ? "R6" : "R3";
    else rq = hit ? "R5" : "R3";

    if (!we) begin
      if (hit) e_rd = cdat[idx][w];
      else if (cach) begin
        e_fill = 8;
        if (mv[idx] && md[idx]) begin e_ev = 8; model_evict(idx); end
        model_fill(idx, tag);
        e_rd = cdat[idx][w];
      end else begin
        e_wr = 1;
        e_rd = ext[wi];
      end
    end else begin
      if (!hit && cach && walloc) begin
        e_fill = 8;
        if (mv[idx] && md[idx]) begin e_ev = 8; model_evict(idx); end
        model_fill(idx, tag);
        hit = 1;
      end
      if (hit) begin
        cdat[idx][w] = merge_be(cdat[idx][w], wd, be);
        if (wb) md[idx] = 1;
        else begin e_ww = 1; ext[wi] = merge_be(ext[wi], wd, be); end
      end else begin
        e_ww = 1;
        ext[wi] = merge_be(ext[wi], wd, be);
      end
    end

    reset_counters();
    mmu_en = mmu; {req_x, req_c, req_b} = xcb; req_write = we;
    req_addr = addr; req_wdata = wd; req_be = be; req_valid = 1;
    do begin
      @(negedge clk);
      cyc++;
    end while (!req_done && cyc < 300);
    chk(req_done, "R11", "request completion", req_done, 1);
    if (!we) chk(req_rdata == e_rd, cach ? "R12" : rq, "load data", req_rdata, e_rd);
    chk(attr_err == err, "R9", "attr_err", attr_err, err);
    chk(fill_beats == e_fill, rq, "fill beats", fill_beats, e_fill);
    chk(ev_beats == e_ev, "R6", "evict beats", ev_beats, e_ev);
    chk(wrd_cnt == e_wr, rq, "word reads", wrd_cnt, e_wr);
    chk(wwr_cnt == e_ww, rq, "word writes", wwr_cnt, e_ww);
    if (e_ww != 0) begin
      chk(seen_buf == e_buf, "R8", "word_buf", seen_buf, e_buf);
      chk(seen_merge == e_mrg, "R8", "word_merge", seen_merge, e_mrg);
    end
    req_valid = 0;
    @(negedge clk);
  endtask

  task automatic do_clean(input int idx);
    int e_ev = (mv[idx] && md[idx]) ? 8 : 0;
    int cyc = 0;
    if (e_ev != 0) model_evict(idx);
    reset_counters();
    clean_index = 2'(idx); clean_valid = 1;
    do begin
      @(negedge clk);
      cyc++;
    end while (!clean_done && cyc < 300);
    chk(clean_done, "R10", "clean completion", clean_done, 1);
    chk(ev_beats == e_ev, "R10", "clean write-back beats", ev_beats, e_ev);
    chk(fill_beats == 0, "R10", "clean fill beats", fill_beats, 0);
    clean_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0; mmu_en = 0; req_valid = 0; req_write = 0; req_addr = '0;
    req_wdata = '0; req_be = '0; req_x = 0; req_c = 0; req_b = 0;
    clean_valid = 0; clean_index = '0;
    for (int i = 0; i < NW; i++) begin
      mem[i] = 32'(i) * 32'h9E3779B9 + 32'h1;
      ext[i] = mem[i];
    end
    for (int i = 0; i < LINES; i++) begin mv[i] = 0; md[i] = 0; mt[i] = 0; end
    reset_counters();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!req_done && !clean_done && !attr_err, "R13", "done/err after reset",
        {req_done, clean_done, attr_err}, 0);
    chk(!line_req && !word_req, "R13", "transfers after reset", {line_req, word_req}, 0);

    for (int n = 0; n < 480; n++) begin
      int k = n % 9;
      bit mmu = (k != 8);
      logic [2:0] xcb = (k == 8) ? 3'b111 : 3'(k);
      bit we = ((n / 9) % 2) == 1;
      logic [31:0] addr = 32'(((n / 18) % 4) * 128 + ((n * 3) % 4) * 32 + ((n * 5) % 8) * 4);
      logic [31:0] wd = 32'(n) * 32'h01000193 ^ 32'hDEAD0000;
      logic [3:0] be = 4'(1 + n % 15);
      do_req(mmu, xcb, we, addr, wd, be);
      if (n % 37 == 36) do_clean(n % LINES);
    end

    // Dirty line, clean, then load must hit with no traffic (R10)
    do_req(1'b1, 3'b111, 1'b1, 32'h0000_0184, 32'h1234_5678, 4'hF);
    do_clean(0);
    do_req(1'b1, 3'b111, 1'b0, 32'h0000_0184, 32'h0, 4'h0);

    for (int i = 0; i < LINES; i++) do_clean(i);
    for (int i = 0; i < NW; i++)
      chk(mem[i] == ext[i], "R6", "final memory word", mem[i], ext[i]);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule